// File: doc/BRIEF.md
# TLB Page Mask and Entry-High Register Writer

This block holds two control registers of a software-managed TLB: the page mask register, which sets the size of the page pair a TLB entry maps, and the entry-high register, which carries the virtual page number, the address-space identifier and an invalidate flag. Software writes arrive through a simple port: a strobe, a register select and a 64-bit value. The block does not store these values as written. It legalizes each one in the same clock cycle, so the registers never hold a value the lookup logic cannot use.

A page mask write is read as a field of mask bits that starts at bit 13. The field is 16 bits wide in normal mode and 47 bits wide in big-page mode. A contiguous low-order run of ones that is large enough for the configured minimum page size is stored as written. Any other value is replaced by a clamped run of ones. In release-6 mode, page mask writes are dropped. An entry-high write keeps only the page-number bits from bit 14 upward, the identifier bits, and the invalidate bit when the configured support level allows it. TLB lookup itself is not part of this block.

Top module: `tlb_pgmask_writer`

## Requirements
- R1: Both registers reset to zero. A register changes only on a clock edge where `wr_en` is high and `wr_sel` selects it (0 = page mask, 1 = entry-high).
- R2: While `rel6_mode` is high, a page mask write leaves the page mask register unchanged.
- R3: The examined field is write bits [13+W-1:13], where W is 47 when `big_page_en` is high and 16 when it is low. Write bits above the field are discarded.
- R4: Let n be the position of the lowest zero bit in the field. A write is legal when no field bit above n is set and n + 12 >= `min_page_bits`. A legal write stores the field at bits 13 upward, with all other bits zero.
- R5: A write with a set field bit above its lowest zero bit is illegal. It stores a run of c+1 ones starting at bit 13. Here c is n raised to at least `min_page_bits` - 12 (or 0 if that is negative) and then capped at W.
- R6: A write with a contiguous field that is too small (n + 12 < `min_page_bits`) stores a run of (`min_page_bits` - 12) + 1 ones from bit 13, provided that count does not exceed W.
- R7: When `min_page_bits` - 12 exceeds W, an illegal write stores a run of W+1 ones from bit 13.
- R8: A field of all ones gives n = W. With the default minimum page size it is legal and is stored whole.
- R9: An entry-high write keeps write bits [63:14] and the identifier bits [ASID_W-1:0] (ASID_W = 8 by default). All other bits read zero, except the invalidate bit.
- R10: The entry-high invalidate bit (bit 10 by default) takes the write value only when `inval_level` >= 2. Otherwise it reads zero.
- R11: Bits [12:0] of the page mask register are always zero, and bits [63:13] always form a contiguous low-order run of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Register select: 0 page mask, 1 entry-high |
| wr_data | input | 64 | Write value |
| rel6_mode | input | 1 | Drops page mask writes when high |
| big_page_en | input | 1 | Widens the mask field from 16 to 47 bits |
| inval_level | input | 2 | Invalidate-support level; 2 or 3 enables the invalidate bit |
| min_page_bits | input | 6 | Minimum page-size exponent accepted |
| pagemask_q | output | 64 | Page mask register |
| entryhi_q | output | 64 | Entry-high register |

## Verification
Each register drives its port directly, so a wrong internal state shows up at the next sampling point after the write that caused it. A wrong lowest-zero count, a wrong clamp bound or a wrong field-width choice each produces a mask of the wrong length in the cycle after the write. Randomized write values bias the field toward near-contiguous runs with stray bits. The minimum page size is swept across its floor and its cap, so each legality branch and each clamp limit is hit many times. A lost or leaked enable bit in the entry-high path shows up in the first write that sets all bits.

// File: rtl/tlb_pgmask_pkg.sv
package tlb_pgmask_pkg;
  localparam int unsigned XLEN  = 64;
  localparam int unsigned CNT_W = 7;

  typedef enum logic {
    SEL_PAGEMASK = 1'b0,
    SEL_ENTRYHI  = 1'b1
  } reg_sel_e;

  // position of the lowest clear bit; XLEN when every bit is set
  function automatic logic [CNT_W-1:0] lowest_zero(input logic [XLEN-1:0] v);
    logic [CNT_W-1:0] r;
    r = CNT_W'(XLEN);
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (!v[i]) r = CNT_W'(i);
    end
    return r;
  endfunction

  // n low-order ones
  function automatic logic [XLEN-1:0] ones_run(input logic [CNT_W-1:0] n);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) begin
      r[i] = (CNT_W'(i) < n);
    end
    return r;
  endfunction

  // clamp a count into [lo, hi]
  function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] v,
                                                 input logic [CNT_W-1:0] lo,
                                                 input logic [CNT_W-1:0] hi);
    logic [CNT_W-1:0] r;
    r = (v < lo) ? lo : v;
    if (r > hi) r = hi;
    return r;
  endfunction
endpackage

// File: rtl/tlb_pm_legalizer.sv
module tlb_pm_legalizer
  import tlb_pgmask_pkg::*;
#(
  parameter int unsigned MASK_LSB  = 13,
  parameter int unsigned W_NARROW  = 16,
  parameter int unsigned W_WIDE    = 47,
  parameter int unsigned BASE_BITS = 12
) (
  input  logic [XLEN-1:0]  wr_data,
  input  logic             big_en,
  input  logic [5:0]       min_pb,
  output logic [XLEN-1:0]  next_mask,
  output logic             illegal,
  output logic [CNT_W-1:0] mask_count
);
  localparam int unsigned TOP_FREE = XLEN - W_WIDE;

  logic [W_WIDE-1:0] field;

  for (genvar g = 0; g < W_WIDE; g++) begin : g_fld
    if (g < W_NARROW) begin : g_base
      assign field[g] = wr_data[MASK_LSB+g];
    end else begin : g_big
      assign field[g] = big_en & wr_data[MASK_LSB+g];
    end
  end

  logic [XLEN-1:0]  field_x;
  logic [CNT_W-1:0] width_lim;
  logic [CNT_W-1:0] floor_cnt;
  logic [CNT_W-1:0] fixed_cnt;
  logic             has_holes;
  logic             too_small;

  assign field_x    = {{TOP_FREE{1'b0}}, field};
  assign mask_count = lowest_zero(field_x);
  assign width_lim  = big_en ? CNT_W'(W_WIDE) : CNT_W'(W_NARROW);

  always_comb begin
    if (min_pb > 6'(BASE_BITS)) floor_cnt = CNT_W'(min_pb) - CNT_W'(BASE_BITS);
    else                        floor_cnt = '0;
  end

  assign has_holes = |(field_x >> mask_count);
  assign too_small = (mask_count < floor_cnt);
  assign illegal   = has_holes | too_small;
  assign fixed_cnt = clamp_cnt(mask_count, floor_cnt, width_lim);

  always_comb begin
    if (illegal) next_mask = ones_run(fixed_cnt + CNT_W'(1)) << MASK_LSB;
    else         next_mask = field_x << MASK_LSB;
  end
endmodule

// File: rtl/tlb_eh_filter.sv
module tlb_eh_filter
  import tlb_pgmask_pkg::*;
#(
  parameter int unsigned VPN_LSB = 14,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned INV_BIT = 10
) (
  input  logic [XLEN-1:0] wr_data,
  input  logic [1:0]      inv_level,
  output logic [XLEN-1:0] keep_mask,
  output logic [XLEN-1:0] next_eh
);
  logic inv_ok;
  assign inv_ok = inv_level[1];

  for (genvar g = 0; g < XLEN; g++) begin : g_keep
    if (g >= VPN_LSB) begin : g_vpn
      assign keep_mask[g] = 1'b1;
    end else if (g < ASID_W) begin : g_asid
      assign keep_mask[g] = 1'b1;
    end else if (g == INV_BIT) begin : g_inv
      assign keep_mask[g] = inv_ok;
    end else begin : g_hole
      assign keep_mask[g] = 1'b0;
    end
  end

  assign next_eh = wr_data & keep_mask;
endmodule

// File: rtl/tlb_cfg_reg.sv
module tlb_cfg_reg #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/tlb_pgmask_writer.sv
module tlb_pgmask_writer
  import tlb_pgmask_pkg::*;
#(
  parameter int unsigned MASK_LSB  = 13,
  parameter int unsigned W_NARROW  = 16,
  parameter int unsigned W_WIDE    = 47,
  parameter int unsigned BASE_BITS = 12,
  parameter int unsigned VPN_LSB   = 14,
  parameter int unsigned ASID_W    = 8,
  parameter int unsigned INV_BIT   = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [XLEN-1:0] wr_data,
  input  logic            rel6_mode,
  input  logic            big_page_en,
  input  logic [1:0]      inval_level,
  input  logic [5:0]      min_page_bits,
  output logic [XLEN-1:0] pagemask_q,
  output logic [XLEN-1:0] entryhi_q
);
  reg_sel_e sel_e;
  assign sel_e = reg_sel_e'(wr_sel);

  // named events for the checker
  logic pm_sel_write;
  logic pm_commit;
  logic eh_commit;

  assign pm_sel_write = wr_en & (sel_e == SEL_PAGEMASK);
  assign pm_commit    = pm_sel_write & ~rel6_mode;
  assign eh_commit    = wr_en & (sel_e == SEL_ENTRYHI);

  logic [XLEN-1:0]  pm_next;
  logic             pm_illegal;
  logic [CNT_W-1:0] pm_count;
  logic [XLEN-1:0]  eh_keep;
  logic [XLEN-1:0]  eh_next;

  tlb_pm_legalizer #(
    .MASK_LSB (MASK_LSB),
    .W_NARROW (W_NARROW),
    .W_WIDE   (W_WIDE),
    .BASE_BITS(BASE_BITS)
  ) u_legal (
    .wr_data   (wr_data),
    .big_en    (big_page_en),
    .min_pb    (min_page_bits),
    .next_mask (pm_next),
    .illegal   (pm_illegal),
    .mask_count(pm_count)
  );

  tlb_eh_filter #(
    .VPN_LSB(VPN_LSB),
    .ASID_W (ASID_W),
    .INV_BIT(INV_BIT)
  ) u_ehf (
    .wr_data  (wr_data),
    .inv_level(inval_level),
    .keep_mask(eh_keep),
    .next_eh  (eh_next)
  );

  tlb_cfg_reg #(.W(XLEN)) u_pm_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (pm_commit),
    .d    (pm_next),
    .q    (pagemask_q)
  );

  tlb_cfg_reg #(.W(XLEN)) u_eh_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (eh_commit),
    .d    (eh_next),
    .q    (entryhi_q)
  );
endmodule

// File: rtl/tlb_pgmask_writer_chk.sv
module tlb_pgmask_writer_chk
  import tlb_pgmask_pkg::*;
#(
  parameter int unsigned MASK_LSB = 13,
  parameter int unsigned W_NARROW = 16,
  parameter int unsigned ASID_W   = 8,
  parameter int unsigned INV_BIT  = 10,
  parameter int unsigned VPN_LSB  = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            rel6_mode,
  input logic            big_page_en,
  input logic [1:0]      inval_level,
  input logic [XLEN-1:0] pagemask_q,
  input logic [XLEN-1:0] entryhi_q,
  input logic            pm_sel_write,
  input logic            eh_commit
);
  logic [XLEN-1:0] pm_run;
  logic [XLEN-1:0] eh_hole;
  assign pm_run = pagemask_q >> MASK_LSB;

  for (genvar g = 0; g < XLEN; g++) begin : g_hole
    if (g >= ASID_W && g < VPN_LSB && g != INV_BIT) begin : g_h
      assign eh_hole[g] = 1'b1;
    end else begin : g_n
      assign eh_hole[g] = 1'b0;
    end
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pagemask_q) && $stable(entryhi_q)));

  // R2
  rel6_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_sel_write && rel6_mode) |=> $stable(pagemask_q));

  // R1
  eh_sel_pm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eh_commit |=> $stable(pagemask_q));

  // R3
  narrow_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_sel_write && !rel6_mode && !big_page_en) |=>
      (pagemask_q >> (MASK_LSB + W_NARROW + 1)) == '0);

  // R11
  pm_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pagemask_q[MASK_LSB-1:0] == '0);

  // R11
  pm_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_run & (pm_run + 1'b1)) == '0);

  // R9
  eh_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entryhi_q & eh_hole) == '0);

  // R10
  eh_inv_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eh_commit && !inval_level[1]) |=> !entryhi_q[INV_BIT]);
endmodule

bind tlb_pgmask_writer tlb_pgmask_writer_chk #(
  .MASK_LSB(MASK_LSB),
  .W_NARROW(W_NARROW),
  .ASID_W  (ASID_W),
  .INV_BIT (INV_BIT),
  .VPN_LSB (VPN_LSB)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .rel6_mode   (rel6_mode),
  .big_page_en (big_page_en),
  .inval_level (inval_level),
  .pagemask_q  (pagemask_q),
  .entryhi_q   (entryhi_q),
  .pm_sel_write(pm_sel_write),
  .eh_commit   (eh_commit)
);

// File: tb/sim_tlb_pgmask_writer.sv
`timescale 1ns/1ps
module sim_tlb_pgmask_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [63:0] wr_data = '0;
  logic        rel6_mode = 1'b0;
  logic        big_page_en = 1'b0;
  logic [1:0]  inval_level = 2'd0;
  logic [5:0]  min_page_bits = 6'd12;
  logic [63:0] pagemask_q;
  logic [63:0] entryhi_q;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_pm = '0;
  logic [63:0] exp_eh = '0;

  always #2.5 clk = ~clk;

  tlb_pgmask_writer u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .rel6_mode    (rel6_mode),
    .big_page_en  (big_page_en),
    .inval_level  (inval_level),
    .min_page_bits(min_page_bits),
    .pagemask_q   (pagemask_q),
    .entryhi_q    (entryhi_q)
  );

  // run of k ones counted from bit 13
  function automatic logic [63:0] run_at13(input int k);
    logic [63:0] v = '0;
    for (int i = 0; i < k; i++) v[13+i] = 1'b1;
    return v;
  endfunction

  function automatic logic [63:0] model_pm(input logic [63:0] d, input logic big,
                                           input int minpb);
    int w, n, lo, c;
    logic [63:0] f;
    logic ok;
    w = big ? 47 : 16;
    f = '0;
    for (int i = 0; i < w; i++) f[i] = d[13+i];
    n = 0;
    while (n < w && f[n]) n++;
    ok = 1'b1;
    for (int i = n; i < 64; i++) if (f[i]) ok = 1'b0;
    if (n + 12 < minpb) ok = 1'b0;
    if (ok) return f << 13;
    lo = (minpb > 12) ? minpb - 12 : 0;
    c = (n < lo) ? lo : n;
    if (c > w) c = w;
    return run_at13(c + 1);
  endfunction

  function automatic logic [63:0] model_eh(input logic [63:0] d, input logic [1:0] lvl);
    logic [63:0] k;
    k = ~64'h3FFF | 64'hFF;
    if (lvl >= 2) k[10] = 1'b1;
    return d & k;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic en, input logic sel, input logic [63:0] d,
                          input string tag);
    @(negedge clk);
    wr_en = en; wr_sel = sel; wr_data = d;
    if (en && !sel && !rel6_mode) exp_pm = model_pm(d, big_page_en, int'(min_page_bits));
    if (en && sel) exp_eh = model_eh(d, inval_level);
    @(negedge clk);
    wr_en = 1'b0;
    chk({tag, " pagemask"}, pagemask_q, exp_pm);
    chk({tag, " entryhi"}, entryhi_q, exp_eh);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset pagemask", pagemask_q, 64'd0);
    chk("R1 reset entryhi", entryhi_q, 64'd0);

    do_write(1'b0, 1'b0, '1, "R1 no strobe");
    do_write(1'b1, 1'b0, 64'h3 << 13, "R4 legal small");
    do_write(1'b1, 1'b1, '1, "R1 R9 R10 eh level0");
    do_write(1'b1, 1'b0, 64'h5 << 13, "R5 hole");
    do_write(1'b1, 1'b0, '1, "R3 R8 narrow all ones");
    big_page_en = 1'b1;
    do_write(1'b1, 1'b0, '1, "R3 R8 wide all ones");
    do_write(1'b1, 1'b0, 64'h7FFFF << 13, "R4 wide legal");
    big_page_en = 1'b0;
    min_page_bits = 6'd20;
    do_write(1'b1, 1'b0, 64'd0, "R6 too small");
    min_page_bits = 6'd63;
    do_write(1'b1, 1'b0, 64'd0, "R7 cap narrow");
    big_page_en = 1'b1;
    do_write(1'b1, 1'b0, 64'h1 << 14, "R7 cap wide");
    big_page_en = 1'b0;
    min_page_bits = 6'd8;
    do_write(1'b1, 1'b0, 64'h0, "R4 zero mask");
    rel6_mode = 1'b1;
    do_write(1'b1, 1'b0, 64'hF << 13, "R2 rel6 drop");
    rel6_mode = 1'b0;
    inval_level = 2'd2;
    do_write(1'b1, 1'b1, '1, "R9 R10 eh level2");
    inval_level = 2'd1;
    do_write(1'b1, 1'b1, 64'h400, "R10 inv blocked");
    inval_level = 2'd3;
    do_write(1'b1, 1'b1, 64'h400, "R10 inv open");
    min_page_bits = 6'd12;

    for (int it = 0; it < 3000; it++) begin
      logic [63:0] d;
      int k;
      k = $urandom_range(0, 50);
      d = {$urandom, $urandom};
      if ($urandom_range(0, 3) != 0) begin
        d = (run_at13(k) & ~64'h0) | (d & ~(~64'h0 << 13));
        if ($urandom_range(0, 2) == 0) d[13 + $urandom_range(0, 48)] = 1'b1;
      end
      big_page_en = 1'($urandom_range(0, 1));
      rel6_mode = ($urandom_range(0, 7) == 0);
      inval_level = 2'($urandom_range(0, 3));
      case ($urandom_range(0, 3))
        0: min_page_bits = 6'($urandom_range(0, 63));
        default: min_page_bits = 6'($urandom_range(10, 18));
      endcase
      do_write(($urandom_range(0, 9) != 0), 1'($urandom_range(0, 1)), d,
               "R2 R3 R4 R5 R6 R7 R9 R10 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule